// File: doc/BRIEF.md
# Protected Byte Update Controller

This block owns a 256-entry, 8-bit nonvolatile store, modelled as registers, and carries out single-byte changes to it. A command decoder hands it an address, a new data byte and a command kind. For an ordinary update the controller compares the stored byte with the new one. It then runs an erase phase only if some bit has to rise from 0 to 1. It runs a write phase only if some bit has to fall from 1 to 0, judged against the byte as it stands after any erase. A phase that no bit needs is skipped. Each phase lasts a configurable number of clock cycles, which stands in for the cell programming time.

The lowest 32 addresses each have a one-time lock bit. A second command kind sets a lock bit, but only when the data byte it carries equals the byte already stored at that address. Once a lock bit is set, only a reset can clear it. An enable input from the security logic gates every change: when it is low, both command kinds complete at once and leave the storage untouched. While phases run, a busy output is high. A one-cycle done pulse marks the end of every accepted command.

A read port with its own address returns the stored byte and its lock bit combinationally.

Top module: `prot_byte_update`

## Requirements
- R1: After reset every stored byte equals the INIT_BYTE parameter, every lock bit reads 0, busy is 0 and done is 0.
- R2: An update (req_kind = 0) runs an erase phase only when at least one bit is 0 in the stored byte and 1 in the new data.
- R3: An update runs a write phase only when the byte it starts from has at least one bit at 1 where the new data has 0. That starting byte is all ones after an erase, or the stored byte when no erase runs.
- R4: After an enabled update to an unlocked address completes, the stored byte equals the new data.
- R5: Each phase lasts exactly PHASE_CYC cycles. Busy is high from the cycle after acceptance until the last phase ends, so it stays high for PHASE_CYC times the number of phases.
- R6: When no phase is needed, busy stays low and done pulses in the cycle after acceptance.
- R7: A lock command (req_kind = 1) sets the lock bit of address A only when A < 32, the enable is high, the lock bit is still clear and req_data equals the stored byte. This uses one phase. Otherwise the command completes at once with no effect.
- R8: A set lock bit never clears until reset. An update to a locked address completes at once and leaves the byte unchanged.
- R9: Addresses 32 to 255 have no lock bit: rd_prot reads 0 for them, and updates to them are never blocked by locking.
- R10: With sec_en low at acceptance, both command kinds complete at once and change neither bytes nor lock bits.
- R11: A request is accepted only while busy is low. Requests made while busy are ignored.
- R12: done is high for exactly one cycle per accepted command, and never while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request strobe |
| req_kind | input | 1 | 0 = byte update, 1 = set lock bit |
| req_addr | input | 8 | Target byte address |
| req_data | input | 8 | New data, or compare data for a lock command |
| sec_en | input | 1 | Change enable from the security logic |
| rd_addr | input | 8 | Read port address |
| rd_data | output | 8 | Stored byte at rd_addr |
| rd_prot | output | 1 | Lock bit of rd_addr (0 for addresses of 32 and above) |
| busy | output | 1 | High while an erase or write phase runs |
| done | output | 1 | One-cycle pulse when a command completes |

## Verification
The bench goes after the phase choice. It uses bytes that need only clearing, only setting, both, or nothing. A design that always erases, or that judges the write need against the old byte instead of the erased one, shows the wrong busy length or the wrong final byte. It probes the lock command with mismatched data, with an address of 32 or above, with the enable low and against an already set bit. A design that skips the data compare or the range check locks the wrong byte. Updates to a locked byte, requests made while busy and a reset after locking check that nothing leaks through. A leak would show as a changed byte or a lock bit that survives reset.

// File: rtl/pbu_pkg.sv
package pbu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_WRITE = 2'd2,
        ST_LOCK  = 2'd3
    } pbu_state_e;

    typedef struct packed {
        pbu_state_e state;
        logic [7:0] addr;
        logic [7:0] data;
        logic       done;
    } pbu_ctl_s;

endpackage

// File: rtl/pbu_phase_need.sv
module pbu_phase_need #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] old_byte,
    input  logic [DATA_W-1:0] new_byte,
    output logic              need_erase,
    output logic              need_write
);
    logic [DATA_W-1:0] rise_bits;
    logic [DATA_W-1:0] base_byte;

    always_comb begin
        rise_bits  = ~old_byte & new_byte;
        need_erase = |rise_bits;
        base_byte  = need_erase ? {DATA_W{1'b1}} : old_byte;
        need_write = |(base_byte & ~new_byte);
    end
endmodule

// File: rtl/pbu_phase_timer.sv
module pbu_phase_timer #(
    parameter int PHASE_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PHASE_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = run && (cnt_q == CNT_MAX);
        cnt_d = cnt_q;
        if (!run || last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    assert_timer_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/pbu_lock_bits.sv
module pbu_lock_bits #(
    parameter int PROT_N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [$clog2(PROT_N)-1:0] set_idx,
    output logic [PROT_N-1:0] lock_vec
);
    logic [PROT_N-1:0] lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (set_en) lock_d[set_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    assign lock_vec = lock_q;

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

    assert_lock_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(lock_q & ~$past(lock_q)) <= 1);
endmodule

// File: rtl/prot_byte_update.sv
module prot_byte_update #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter int          PROT_N    = 32,
    parameter int          PHASE_CYC = 250000,
    parameter logic [7:0]  INIT_BYTE = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_kind,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_data,
    input  logic       sec_en,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       rd_prot,
    output logic       busy,
    output logic       done
);
    import pbu_pkg::*;

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PIDX_W = $clog2(PROT_N);
    localparam logic [ADDR_W:0] PROT_LIM = (ADDR_W + 1)'(PROT_N);

    pbu_ctl_s ctl_d, ctl_q;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    logic [PROT_N-1:0] lock_vec;
    logic              lock_set;
    logic [DATA_W-1:0] req_old;
    logic              req_low;
    logic              req_locked;
    logic              need_erase;
    logic              need_write;
    logic              phase_last;
    logic              run;
    logic              cur_low;
    logic              cur_locked;

    pbu_phase_need #(.DATA_W(DATA_W)) need_i (
        .old_byte   (req_old),
        .new_byte   (req_data),
        .need_erase (need_erase),
        .need_write (need_write)
    );

    pbu_phase_timer #(.PHASE_CYC(PHASE_CYC)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .last  (phase_last)
    );

    pbu_lock_bits #(.PROT_N(PROT_N)) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (lock_set),
        .set_idx  (ctl_q.addr[PIDX_W-1:0]),
        .lock_vec (lock_vec)
    );

    always_comb begin
        req_old    = mem_q[req_addr];
        req_low    = {1'b0, req_addr} < PROT_LIM;
        req_locked = req_low && lock_vec[req_addr[PIDX_W-1:0]];
        cur_low    = {1'b0, ctl_q.addr} < PROT_LIM;
        cur_locked = cur_low && lock_vec[ctl_q.addr[PIDX_W-1:0]];
        run        = (ctl_q.state != ST_IDLE);
        rd_data    = mem_q[rd_addr];
        rd_prot    = ({1'b0, rd_addr} < PROT_LIM) && lock_vec[rd_addr[PIDX_W-1:0]];
        busy       = run;
        done       = ctl_q.done;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        mem_we     = 1'b0;
        mem_waddr  = ctl_q.addr;
        mem_wdata  = mem_q[ctl_q.addr];
        lock_set   = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr = req_addr;
                    ctl_d.data = req_data;
                    ctl_d.done = 1'b1;
                    if (!req_kind) begin
                        if (sec_en && !req_locked) begin
                            if (need_erase) begin
                                ctl_d.state = ST_ERASE;
                                ctl_d.done  = 1'b0;
                            end else if (need_write) begin
                                ctl_d.state = ST_WRITE;
                                ctl_d.done  = 1'b0;
                            end
                        end
                    end else begin
                        if (sec_en && req_low && !req_locked && (req_old == req_data)) begin
                            ctl_d.state = ST_LOCK;
                            ctl_d.done  = 1'b0;
                        end
                    end
                end
            end
            ST_ERASE: begin
                if (phase_last) begin
                    mem_we    = 1'b1;
                    mem_wdata = {DATA_W{1'b1}};
                    if (ctl_q.data != {DATA_W{1'b1}}) begin
                        ctl_d.state = ST_WRITE;
                    end else begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.done  = 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                if (phase_last) begin
                    mem_we      = 1'b1;
                    mem_wdata   = mem_q[ctl_q.addr] & ctl_q.data;
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end
            end
            ST_LOCK: begin
                if (phase_last) begin
                    lock_set    = 1'b1;
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.addr  <= '0;
            ctl_q.data  <= '0;
            ctl_q.done  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT_BYTE;
        end else begin
            ctl_q <= ctl_d;
            if (mem_we) mem_q[mem_waddr] <= mem_wdata;
        end
    end

    assert_locked_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !cur_locked);

    assert_gate_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sec_en));

    assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_lock_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_set |-> cur_low);

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctl_q.addr));
endmodule

// File: tb/prot_byte_update_tb_top.sv
module prot_byte_update_tb_top;
    localparam int         PC   = 3;
    localparam logic [7:0] INIT = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_kind = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       sec_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       rd_prot;
    logic       busy;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    prot_byte_update #(.PHASE_CYC(PC), .INIT_BYTE(INIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data), .sec_en(sec_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_prot(rd_prot),
        .busy(busy), .done(done)
    );

    // kind, addr, data, sec, expected byte, expected phases, expected lock bit
    localparam int NV = 16;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 8'd40,  8'h5A, 1'b1, 8'h5A, 2'd0, 1'b0}, // R6 nothing to do
        {1'b0, 8'd40,  8'h50, 1'b1, 8'h50, 2'd1, 1'b0}, // R3 write only
        {1'b0, 8'd40,  8'hF0, 1'b1, 8'hF0, 2'd2, 1'b0}, // R2 erase + write
        {1'b0, 8'd40,  8'hFF, 1'b1, 8'hFF, 2'd1, 1'b0}, // R2 erase only
        {1'b0, 8'd41,  8'h00, 1'b0, 8'h5A, 2'd0, 1'b0}, // R10 gated update
        {1'b0, 8'd5,   8'h12, 1'b1, 8'h12, 2'd1, 1'b0}, // R4 low addr unlocked
        {1'b1, 8'd5,   8'h34, 1'b1, 8'h12, 2'd0, 1'b0}, // R7 mismatch
        {1'b1, 8'd5,   8'h12, 1'b1, 8'h12, 2'd1, 1'b1}, // R7 lock set
        {1'b0, 8'd5,   8'hFF, 1'b1, 8'h12, 2'd0, 1'b1}, // R8 locked update
        {1'b1, 8'd5,   8'h12, 1'b1, 8'h12, 2'd0, 1'b1}, // R8 relock no-op
        {1'b1, 8'd40,  8'hFF, 1'b1, 8'hFF, 2'd0, 1'b0}, // R9 lock out of range
        {1'b0, 8'd31,  8'h00, 1'b0, 8'h5A, 2'd0, 1'b0}, // R10 gated
        {1'b1, 8'd31,  8'h5A, 1'b0, 8'h5A, 2'd0, 1'b0}, // R10 gated lock
        {1'b0, 8'd31,  8'h00, 1'b1, 8'h00, 2'd1, 1'b0}, // R4 top of lock range
        {1'b0, 8'd255, 8'hA5, 1'b1, 8'hA5, 2'd2, 1'b0}, // R9 high addr
        {1'b0, 8'd0,   8'h5B, 1'b1, 8'h5B, 2'd2, 1'b0}  // R2 single rising bit
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one request, return busy cycles seen before done
    task automatic issue(input logic k, input logic [7:0] a, input logic [7:0] d,
                         input logic s, output int bcnt, output int dcnt);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_data = d; sec_en = s;
        @(negedge clk);
        req_valid = 1'b0;
        bcnt = 0; dcnt = 0;
        for (int g = 0; g < 40 && !done; g++) begin
            if (busy) bcnt++;
            @(negedge clk);
        end
        if (done) begin
            dcnt = 1;
            @(negedge clk);
            if (done) dcnt++;
        end
    endtask

    initial begin
        int bc, dc;
        rd_addr = 8'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            rd_addr = 8'(i); #1;
            check("R1 lock clear", rd_prot, 0);
            check("R1 init byte", rd_data, INIT);
        end
        rd_addr = 8'd200; #1;
        check("R1 init byte high", rd_data, INIT);

        for (int v = 0; v < NV; v++) begin
            logic [28:0] e;
            e = VEC[v];
            issue(e[28], e[27:20], e[19:12], e[11], bc, dc);
            check("R5 busy length", bc, int'(e[2:1]) * PC);
            check("R12 done once", dc, 1);
            rd_addr = e[27:20]; #1;
            check("R4 stored byte", rd_data, e[10:3]);
            check("R7 lock bit", rd_prot, e[0]);
        end
        rd_addr = 8'd41; #1;
        check("R10 byte untouched", rd_data, INIT);

        // R11 request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_kind = 1'b0; req_addr = 8'd50; req_data = 8'h00; sec_en = 1'b1;
        @(negedge clk);
        check("R5 busy after accept", busy, 1);
        req_addr = 8'd51;
        @(negedge clk);
        req_valid = 1'b0;
        for (int g = 0; g < 40 && !done; g++) @(negedge clk);
        repeat (3) @(negedge clk);
        rd_addr = 8'd51; #1;
        check("R11 ignored while busy", rd_data, INIT);
        rd_addr = 8'd50; #1;
        check("R4 accepted byte", rd_data, 8'h00);

        // R8 lock survives until reset only
        rd_addr = 8'd5; #1;
        check("R8 lock held", rd_prot, 1);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lock cleared by reset", rd_prot, 0);
        check("R1 byte reinit", rd_data, INIT);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule